// File: doc/BRIEF.md
# Host-to-DRP Command Bridge

The bridge turns one host-written command word into exactly one access on one of six dynamic-reconfiguration ports. The targets are four per-lane channel blocks, one shared PLL block and one clock-manager block. The top four bits of the command choose both the target and the direction. The next twelve bits give the register address inside the target. The low sixteen bits carry the value to be written.

The host bus is reduced to a write strobe with an address and a data word. The status is presented as level outputs that the host may read at any time.

While an access is outstanding, the bridge raises a busy flag and rejects further commands. When a read completes, the bridge captures the returned data together with the code and address that requested it, so that the host can match each answer to its question. A target that never answers is abandoned after a fixed number of cycles. Malformed commands and commands sent too early are reported through flags.

Top module: `drp_cmd_bridge`

## Requirements
- R1: After reset, busy, err_flag, ovr_flag and tmo_flag are 0, host_status is 0, and no drp_en or drp_we bit is high.
- R2: Command word layout is code [31:28], register address [27:16] and data [15:0]. Code bit 31 = 1 means write and 0 means read. Code bits [30:28] select the target: 0 to 3 are lanes 0 to 3, 4 is the shared PLL and 5 is the clock manager. So 0x8 to 0xB and 0x0 to 0x3 write and read the lanes, 0xC and 0x4 write and read the shared PLL, and 0xD and 0x5 write and read the clock manager. While the port's enable is high, the selected port's drp_addr and drp_di slices carry the command's address and data.
- R3: A command is taken only when host_wr is high and host_waddr equals 0x0C8. A strobe at any other offset changes nothing.
- R4: An accepted command raises drp_en of the selected target alone, for exactly one cycle, in the cycle after the strobe. The matching drp_we bit is high in that cycle for write codes only.
- R5: busy is high from the cycle after acceptance until the cycle after the selected drp_rdy is seen. No drp_en is raised again during that time.
- R6: When a read completes, host_status takes {code, address, returned 16-bit data} in the cycle after drp_rdy. Completed writes leave host_status unchanged.
- R7: Codes 0x6, 0x7, 0xE and 0xF start no access and set err_flag. The next accepted valid command clears err_flag.
- R8: A strobe at 0x0C8 while busy is dropped and sets ovr_flag, which stays set until reset. The access in flight completes unaffected.
- R9: If the selected drp_rdy is not seen within 256 cycles after the enable cycle, the access is abandoned: busy falls, tmo_flag is set and host_status is unchanged. A drp_rdy that arrives later is ignored. The next accepted valid command clears tmo_flag.
- R10: drp_rdy from targets other than the selected one, or drp_rdy in the enable cycle itself, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | 12 | Host write offset |
| host_wdata | input | 32 | Command word |
| host_status | output | 32 | Last read result: {code, address, data} |
| busy | output | 1 | Access in flight |
| err_flag | output | 1 | Last command had an unused code |
| ovr_flag | output | 1 | Sticky: a command arrived while busy |
| tmo_flag | output | 1 | Last access timed out |
| drp_en | output | 6 | Per-target enable pulse |
| drp_we | output | 6 | Per-target write enable |
| drp_addr | output | 72 | Per-target register address, 12 bits each, target 0 lowest |
| drp_di | output | 96 | Per-target write data, 16 bits each |
| drp_do | input | 96 | Per-target read data, 16 bits each |
| drp_rdy | input | 6 | Per-target ready |

## Verification
Several rules are checked by the assertions on every cycle:
- at most one enable is high at a time, and it lasts one cycle;
- a write enable appears only with its enable;
- an enable appears only as busy rises;
- acceptance, unused codes, overruns and abandonment each leave the expected flag one cycle later;
- the status word moves only on a completed access.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- which port receives which address and data for each code;
- that status holds the right triple after reads;
- that strobes at other offsets and stray or late ready pulses change nothing;
- the exact timeout boundary, where a ready in the last waiting cycle still completes and one a cycle later does not.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
  localparam int NUM_LANES = 4;
  localparam int NUM_TGT   = NUM_LANES + 2;
  localparam int SEL_W     = 3;
  localparam int CODE_W    = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_t;

  // Target field of a code: lanes first, then shared PLL, then clock manager.
  function automatic logic [SEL_W-1:0] code_target(input logic [CODE_W-1:0] code);
    return code[SEL_W-1:0];
  endfunction

  function automatic logic code_is_write(input logic [CODE_W-1:0] code);
    return code[CODE_W-1];
  endfunction

  function automatic logic code_is_valid(input logic [CODE_W-1:0] code);
    return code_target(code) < SEL_W'(NUM_TGT);
  endfunction
endpackage

// File: rtl/drp_cmd_decode.sv
module drp_cmd_decode
  import drp_bridge_pkg::*;
#(
  parameter int HAW = 12,
  parameter logic [HAW-1:0] OFFSET = 12'h0C8,
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CW = CODE_W + AW + DW
) (
  input  logic              host_wr,
  input  logic [HAW-1:0]    host_waddr,
  input  logic [CW-1:0]     host_wdata,
  output logic              cmd_hit,
  output logic              cmd_ok,
  output logic              cmd_wr,
  output logic [SEL_W-1:0]  cmd_sel,
  output logic [CODE_W-1:0] cmd_code,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_data
);
  assign cmd_hit  = host_wr && (host_waddr == OFFSET);
  assign cmd_code = host_wdata[CW-1 -: CODE_W];
  assign cmd_addr = host_wdata[DW +: AW];
  assign cmd_data = host_wdata[DW-1:0];
  assign cmd_ok   = code_is_valid(cmd_code);
  assign cmd_wr   = code_is_write(cmd_code);
  assign cmd_sel  = code_target(cmd_code);
endmodule

// File: rtl/drp_sequencer.sv
module drp_sequencer
  import drp_bridge_pkg::*;
#(
  parameter int TIMEOUT = 256,
  parameter int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rdy,
  output logic issue,
  output logic busy,
  output logic done_evt,
  output logic abandon_evt
);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  seq_state_t    state;
  logic [TW-1:0] wait_cnt;

  assign issue       = (state == SEQ_ISSUE);
  assign busy        = (state != SEQ_IDLE);
  assign done_evt    = (state == SEQ_WAIT) && rdy;
  assign abandon_evt = (state == SEQ_WAIT) && !rdy && (wait_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      wait_cnt <= '0;
    end else begin
      case (state)
        SEQ_IDLE:  if (start) state <= SEQ_ISSUE;
        SEQ_ISSUE: begin
          state    <= SEQ_WAIT;
          wait_cnt <= '0;
        end
        SEQ_WAIT: begin
          if (done_evt || abandon_evt) state <= SEQ_IDLE;
          else wait_cnt <= wait_cnt + 1'b1;
        end
        default:   state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drp_port_fanout.sv
module drp_port_fanout #(
  parameter int NT = 6,
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int SW = 3
) (
  input  logic          issue,
  input  logic          wr,
  input  logic [SW-1:0] sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [NT*DW-1:0] drp_do,
  input  logic [NT-1:0] drp_rdy,
  output logic [NT-1:0] drp_en,
  output logic [NT-1:0] drp_we,
  output logic [NT*AW-1:0] drp_addr,
  output logic [NT*DW-1:0] drp_di,
  output logic          rdy_sel,
  output logic [DW-1:0] do_sel
);
  for (genvar i = 0; i < NT; i++) begin : g_port
    assign drp_en[i]             = issue && (sel == SW'(i));
    assign drp_we[i]             = drp_en[i] && wr;
    assign drp_addr[i*AW +: AW]  = addr;
    assign drp_di[i*DW +: DW]    = data;
  end

  assign rdy_sel = drp_rdy[sel];
  assign do_sel  = drp_do[int'(sel)*DW +: DW];
endmodule

// File: rtl/drp_cmd_bridge.sv
module drp_cmd_bridge
  import drp_bridge_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int HAW = 12,
  parameter logic [HAW-1:0] CMD_OFFSET = 12'h0C8,
  parameter int TIMEOUT = 256,
  localparam int CW = CODE_W + AW + DW,
  localparam int NT = NUM_TGT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [HAW-1:0]   host_waddr,
  input  logic [CW-1:0]    host_wdata,
  output logic [CW-1:0]    host_status,
  output logic             busy,
  output logic             err_flag,
  output logic             ovr_flag,
  output logic             tmo_flag,
  output logic [NT-1:0]    drp_en,
  output logic [NT-1:0]    drp_we,
  output logic [NT*AW-1:0] drp_addr,
  output logic [NT*DW-1:0] drp_di,
  input  logic [NT*DW-1:0] drp_do,
  input  logic [NT-1:0]    drp_rdy
);
  logic              cmd_hit, cmd_ok, cmd_wr;
  logic [SEL_W-1:0]  cmd_sel;
  logic [CODE_W-1:0] cmd_code;
  logic [AW-1:0]     cmd_addr;
  logic [DW-1:0]     cmd_data;

  logic              wr_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CODE_W-1:0] code_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;

  logic issue, rdy_sel, done_evt, abandon_evt;
  logic [DW-1:0] do_sel;

  // Named events, also observed by the bound checker.
  logic accept_evt, bad_evt, ovr_evt;
  assign accept_evt = cmd_hit && !busy && cmd_ok;
  assign bad_evt    = cmd_hit && !busy && !cmd_ok;
  assign ovr_evt    = cmd_hit && busy;

  drp_cmd_decode #(
    .HAW(HAW), .OFFSET(CMD_OFFSET), .AW(AW), .DW(DW), .CW(CW)
  ) u_dec (
    .host_wr(host_wr), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .cmd_hit(cmd_hit), .cmd_ok(cmd_ok), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  drp_sequencer #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept_evt), .rdy(rdy_sel),
    .issue(issue), .busy(busy), .done_evt(done_evt), .abandon_evt(abandon_evt)
  );

  drp_port_fanout #(.NT(NT), .AW(AW), .DW(DW), .SW(SEL_W)) u_fan (
    .issue(issue), .wr(wr_q), .sel(sel_q), .addr(addr_q), .data(data_q),
    .drp_do(drp_do), .drp_rdy(drp_rdy), .drp_en(drp_en), .drp_we(drp_we),
    .drp_addr(drp_addr), .drp_di(drp_di), .rdy_sel(rdy_sel), .do_sel(do_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q        <= 1'b0;
      sel_q       <= '0;
      code_q      <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      host_status <= '0;
      err_flag    <= 1'b0;
      ovr_flag    <= 1'b0;
      tmo_flag    <= 1'b0;
    end else begin
      if (accept_evt) begin
        wr_q     <= cmd_wr;
        sel_q    <= cmd_sel;
        code_q   <= cmd_code;
        addr_q   <= cmd_addr;
        data_q   <= cmd_data;
        err_flag <= 1'b0;
        tmo_flag <= 1'b0;
      end
      if (bad_evt)     err_flag <= 1'b1;
      if (ovr_evt)     ovr_flag <= 1'b1;
      if (abandon_evt) tmo_flag <= 1'b1;
      if (done_evt && !wr_q) host_status <= {code_q, addr_q, do_sel};
    end
  end
endmodule

// File: rtl/drp_cmd_bridge_chk.sv
module drp_cmd_bridge_chk #(
  parameter int NT = 6,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [NT-1:0] drp_en,
  input logic [NT-1:0] drp_we,
  input logic          err_flag,
  input logic          ovr_flag,
  input logic          tmo_flag,
  input logic          accept_evt,
  input logic          bad_evt,
  input logic          ovr_evt,
  input logic          done_evt,
  input logic          abandon_evt,
  input logic [CW-1:0] host_status
);
  assert_en_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drp_en));

  assert_en_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|drp_en) |=> (drp_en == '0));

  assert_we_with_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((drp_we & ~drp_en) == '0));

  assert_en_only_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|drp_en) |-> $rose(busy));

  assert_accept_issues_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (busy && (|drp_en)));

  assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> (err_flag && !busy && (drp_en == '0)));

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (ovr_flag && (drp_en == '0)));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |=> ovr_flag);

  assert_timeout_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abandon_evt |=> (tmo_flag && !busy));

  assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(host_status));
endmodule

bind drp_cmd_bridge drp_cmd_bridge_chk #(.NT(NT), .CW(CW)) u_chk (.*);

// File: tb/drp_cmd_bridge_test.sv
module drp_cmd_bridge_test;
  localparam int TMO = 256;
  localparam logic [11:0] OFS = 12'h0C8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [11:0] host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_status;
  logic busy, err_flag, ovr_flag, tmo_flag;
  logic [5:0] drp_en, drp_we;
  logic [71:0] drp_addr;
  logic [95:0] drp_di, drp_do;
  logic [5:0] drp_rdy;

  logic [5:0] resp = '0;
  logic [5:0] stray = '0;
  logic [15:0] salt = 16'h0000;
  integer rsp_delay = 1;
  integer cd = 0;
  integer rt = 0;

  integer checks = 0;
  integer errors = 0;
  integer en_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  drp_cmd_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_status(host_status), .busy(busy),
    .err_flag(err_flag), .ovr_flag(ovr_flag), .tmo_flag(tmo_flag),
    .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
    .drp_do(drp_do), .drp_rdy(drp_rdy)
  );

  function automatic logic [15:0] do_val(input integer t);
    return 16'((t + 1) * 16'h1111) ^ salt;
  endfunction

  for (genvar g = 0; g < 6; g++) begin : g_do
    assign drp_do[g*16 +: 16] = do_val(g);
  end
  assign drp_rdy = resp | stray;

  // Target responder: ready comes rsp_delay cycles after the enable cycle.
  always @(posedge clk) begin
    resp <= '0;
    if (drp_en != '0) begin
      for (int t = 0; t < 6; t++) if (drp_en[t]) rt = t;
      cd = rsp_delay;
    end
    if (cd > 0) begin
      if (cd == 1) resp <= 6'(1 << rt);
      cd = cd - 1;
    end
  end

  // Reference model, one step per clock.
  integer m_phase = 0, m_cnt = 0, m_tgt = 0;
  bit m_wr = 0, m_err = 0, m_ovr = 0, m_tmo = 0;
  logic [3:0] m_code = '0;
  logic [11:0] m_addr = '0;
  logic [15:0] m_data = '0;
  logic [31:0] m_status = '0;

  always @(posedge clk) begin
    bit hit;
    logic [3:0] c;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_tgt = 0; m_wr = 0; m_err = 0; m_ovr = 0;
      m_tmo = 0; m_status = '0;
    end else begin
      hit = host_wr && (host_waddr == OFS);
      c = host_wdata[31:28];
      if (m_phase == 0) begin
        if (hit) begin
          if (int'(c[2:0]) <= 5) begin
            m_phase = 1; m_tgt = int'(c[2:0]); m_wr = c[3]; m_code = c;
            m_addr = host_wdata[27:16]; m_data = host_wdata[15:0];
            m_err = 0; m_tmo = 0;
          end else m_err = 1;
        end
      end else if (m_phase == 1) begin
        if (hit) m_ovr = 1;
        m_phase = 2; m_cnt = 0;
      end else begin
        if (hit) m_ovr = 1;
        if (drp_rdy[m_tgt]) begin
          m_phase = 0;
          if (!m_wr) m_status = {m_code, m_addr, do_val(m_tgt)};
        end else if (m_cnt == TMO - 1) begin
          m_phase = 0; m_tmo = 1;
        end else m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [5:0] exp_en;
    if (rst_n && !done) begin
      if (|drp_en) en_cnt++;
      exp_en = (m_phase == 1) ? 6'(1 << m_tgt) : 6'd0;
      chk("R5 busy", {31'd0, busy}, {31'd0, m_phase != 0});
      chk("R4 drp_en", {26'd0, drp_en}, {26'd0, exp_en});
      chk("R4 drp_we", {26'd0, drp_we}, {26'd0, m_wr ? exp_en : 6'd0});
      chk("R6 host_status", host_status, m_status);
      chk("R7 err_flag", {31'd0, err_flag}, {31'd0, m_err});
      chk("R8 ovr_flag", {31'd0, ovr_flag}, {31'd0, m_ovr});
      chk("R9 tmo_flag", {31'd0, tmo_flag}, {31'd0, m_tmo});
      if (m_phase == 1) begin
        chk("R2 drp_addr", {20'd0, drp_addr[m_tgt*12 +: 12]}, {20'd0, m_addr});
        chk("R2 drp_di", {16'd0, drp_di[m_tgt*16 +: 16]}, {16'd0, m_data});
      end
    end
  end

  task automatic send(input logic [31:0] w, input logic [11:0] a);
    @(posedge clk); #1;
    host_wr = 1'b1; host_waddr = a; host_wdata = w;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    integer n0;
    logic [31:0] snap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset busy/flags", {28'd0, busy, err_flag, ovr_flag, tmo_flag}, 32'd0);
    chk("R1 reset status", host_status, 32'd0);
    chk("R1 reset enables", {20'd0, drp_en, 6'd0} | {26'd0, drp_we}, 32'd0);

    // R2/R4: writes to every target with varying latency
    for (int t = 0; t < 6; t++) begin
      rsp_delay = t + 1;
      send({1'b1, 3'(t), 12'(12'h05E + t * 7), 16'(16'h1002 + t * 16'h0101)}, OFS);
      wait_idle();
    end
    chk("R6 write leaves status", host_status, 32'd0);

    // R2/R6: reads from every target
    for (int t = 0; t < 6; t++) begin
      salt = 16'(t * 16'h0F0F);
      rsp_delay = 6 - t;
      send({1'b0, 3'(t), 12'(12'h088 + t), 16'hBEEF}, OFS);
      wait_idle();
      chk("R6 read triple", host_status, {1'b0, 3'(t), 12'(12'h088 + t), do_val(t)});
    end

    // R6: a write after a read does not alter status
    snap = host_status;
    send(32'hD0081042, OFS);
    wait_idle();
    chk("R6 status after write", host_status, snap);

    // R3: wrong offset ignored
    n0 = en_cnt;
    send(32'h40360020, 12'h0C4);
    send(32'hC0360020, 12'h1C8);
    wait_idle();
    chk("R3 no access at other offset", en_cnt, n0);
    chk("R3 status kept", host_status, snap);

    // R7: unused codes
    for (int k = 0; k < 4; k++) begin
      logic [3:0] bc;
      bc = (k == 0) ? 4'h6 : (k == 1) ? 4'h7 : (k == 2) ? 4'hE : 4'hF;
      n0 = en_cnt;
      send({bc, 12'h016, 16'h2083}, OFS);
      @(negedge clk);
      chk("R7 err set", {31'd0, err_flag}, 32'd1);
      chk("R7 no access", en_cnt, n0);
    end
    rsp_delay = 2;
    send(32'h40360000, OFS);
    wait_idle();
    chk("R7 err cleared by valid command", {31'd0, err_flag}, 32'd0);

    // R8: overrun while busy
    rsp_delay = 10;
    salt = 16'h3C3C;
    send(32'h01230000, OFS);
    send(32'h5FFF0000, OFS);
    wait_idle();
    chk("R8 overrun flagged", {31'd0, ovr_flag}, 32'd1);
    chk("R8 first read intact", host_status, {4'h0, 12'h123, do_val(0)});
    chk("R8 single access", en_cnt, n0 + 2);

    // R10: stray ready from other targets ignored
    rsp_delay = 20;
    send(32'h20A90000, OFS);
    @(posedge clk); #1 stray = 6'b111011;
    repeat (5) @(posedge clk);
    #1 stray = '0;
    @(negedge clk);
    chk("R10 still busy under stray ready", {31'd0, busy}, 32'd1);
    wait_idle();
    chk("R10 read completes", host_status, {4'h2, 12'h0A9, do_val(2)});

    // R9: no response at all
    rsp_delay = 0;
    send(32'h30AA0000, OFS);
    wait_idle();
    chk("R9 timeout flagged", {31'd0, tmo_flag}, 32'd1);
    chk("R9 status kept", host_status, {4'h2, 12'h0A9, do_val(2)});

    // R9: ready in the last allowed cycle completes
    rsp_delay = TMO;
    salt = 16'h0001;
    send(32'h50180000, OFS);
    wait_idle();
    chk("R9 last-cycle ready completes", {31'd0, tmo_flag}, 32'd0);
    chk("R9 last-cycle read data", host_status, {4'h5, 12'h018, do_val(5)});

    // R9: ready one cycle late is abandoned and then ignored
    rsp_delay = TMO + 1;
    salt = 16'h7777;
    snap = host_status;
    send(32'h404F0000, OFS);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R9 late ready abandoned", {31'd0, tmo_flag}, 32'd1);
    chk("R9 late ready ignored", host_status, snap);
    chk("R9 idle after abandon", {31'd0, busy}, 32'd0);

    finish_run();
  end
endmodule